// File: doc/BRIEF.md
# Duplicate-Tag Snoop Controller

This block keeps the private L1 data caches of several CPUs coherent under the four-state MESI protocol. It holds its own copy of every CPU's L1 tag and state array, one entry per L1 line. The L1 caches are direct-mapped, so an entry is chosen by the line index alone. When a CPU misses, or needs write ownership of a line it already holds, it raises a request. The block picks one requester per cycle and looks the line up in the duplicate arrays of all the other CPUs. It then issues coherency commands only to the CPUs that really hold the line.

The block serves a miss from another CPU's L1 whenever another CPU holds the line. A clean line is copied across and both copies end up Shared. A Modified line migrates: the requester takes it as Modified, and the old owner drops it without first writing it back. Only a line that no other CPU holds goes to the next level. A dirty victim that a fill displaces is written back to the next level. The duplicate arrays are updated on the same clock edge as the grant, so they never lag the L1 state.

All responses for the granted request are combinational in the grant cycle. The requester holds its request until it sees its grant bit.

Top module: `snoop_filter_ctl`

## Requirements
- R1: State codes are Invalid=0, Shared=1, Exclusive=2, Modified=3. Line address = {tag, index}, with the index in the low IDX_W bits. After reset every duplicate entry is Invalid, and with no request every output is zero.
- R2: A read miss (op[1]=0, op[0]=0) that no other CPU holds asserts nl_fetch with nl_addr equal to the request address. It grants Exclusive with no snoop and no transfer.
- R3: A read miss that other CPUs hold clean sends a share command (snp_op=0) only to the lowest-numbered holder. That holder supplies the data (xfer_valid, xfer_src) and the grant is Shared. The holder's copy becomes Shared, and nothing is fetched.
- R4: A read miss on a line another CPU holds Modified migrates the line. The owner alone gets an invalidate (snp_op=1) and supplies the data, the grant is Modified and the owner's copy becomes Invalid. There is no fetch and no writeback of that line.
- R5: A write miss (op[1]=0, op[0]=1) invalidates every other holder and takes the data from the lowest-numbered holder. With no holder it fetches from the next level. Either way it grants Modified.
- R6: An upgrade (op[1]=1) invalidates only the other holders, moves no data, fetches nothing and grants Modified.
- R7: snp_mask never contains the requester or a CPU whose duplicate entry lacks the line. snp_op is 1 only for an invalidate and is 0 whenever snp_mask is zero.
- R8: A read or write miss whose own entry at that index holds a different tag in Modified asserts nl_wb with nl_wb_addr = {old tag, index}. A clean victim causes no writeback.
- R9: The duplicate entries of the requester and of the snooped CPUs take their new states on the grant edge, so a request in the very next cycle sees them.
- R10: At most one grant per cycle. The winner is the first requester at or after a rotating pointer, and the pointer moves to the winner plus one.
- R11: No grant is given to a CPU whose req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NCPU | Request per CPU, held until granted |
| req_op | input | 2*NCPU | Per CPU: bit1 upgrade, bit0 write (miss) |
| req_addr | input | NCPU*AW | Per CPU line address {tag, index} |
| gnt | output | NCPU | One-hot grant |
| gnt_state | output | 2 | State the requester installs |
| snp_mask | output | NCPU | CPUs receiving a snoop command |
| snp_op | output | 1 | 0 share and supply, 1 invalidate |
| xfer_valid | output | 1 | A cache-to-cache data transfer occurs |
| xfer_src | output | CW | CPU supplying the data |
| nl_fetch | output | 1 | Fetch the line from the next level |
| nl_addr | output | AW | Fetch address |
| nl_wb | output | 1 | Write a dirty victim to the next level |
| nl_wb_addr | output | AW | Victim address |

## Verification
The assertions assume that every request matches the requester's own L1 state. An upgrade comes only for a line the requester holds Shared or Exclusive under the same tag. A read or write miss comes only for a tag the requester does not hold. Given that, the duplicate arrays keep the single-owner invariant the assertions rely on. The stimulus picks each CPU's operation from the bench's own state model: it turns a hit into an upgrade, suppresses a request for a line already held Modified, and otherwise issues a read or write miss. It draws tags from a small pool, so sharing, migration and victim eviction occur often.

// File: rtl/scu_pkg.sv
package scu_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;
endpackage

// File: rtl/scu_rr_arb.sv
module scu_rr_arb #(
  parameter int NCPU = 4,
  localparam int CW = $clog2(NCPU)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] req,
  output logic [NCPU-1:0] gnt,
  output logic            win_valid,
  output logic [CW-1:0]   win_idx
);
  logic [CW-1:0] ptr_q, ptr_d;

  always_comb begin
    gnt       = '0;
    win_valid = 1'b0;
    win_idx   = '0;
    for (int k = 0; k < NCPU; k++) begin
      if (!win_valid && req[(int'(ptr_q) + k) % NCPU]) begin
        win_valid = 1'b1;
        win_idx   = CW'((int'(ptr_q) + k) % NCPU);
        gnt[(int'(ptr_q) + k) % NCPU] = 1'b1;
      end
    end
    ptr_d = (int'(win_idx) == NCPU - 1) ? '0 : win_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (win_valid) ptr_q <= ptr_d;
  end

  // R10: never more than one grant
  a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R11: grant only to a requesting CPU
  a_r11_grant_has_request: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
endmodule

// File: rtl/scu_dup_tags.sv
module scu_dup_tags
  import scu_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int IDX_W = 3,
  parameter int TAG_W = 6,
  localparam int SETS = 1 << IDX_W,
  localparam int CW   = $clog2(NCPU)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           lk_idx,
  input  logic [TAG_W-1:0]           lk_tag,
  input  logic [CW-1:0]              req_cpu,
  output logic [NCPU-1:0]            others_hit,
  output logic [NCPU-1:0][1:0]       look_st,
  output mesi_e                      own_st,
  output logic [TAG_W-1:0]           own_tag,
  input  logic                       upd_en,
  input  mesi_e                      upd_st,
  input  logic [NCPU-1:0]            snp_mask,
  input  logic                       snp_op
);
  logic [NCPU-1:0][TAG_W-1:0] tag_rd;
  logic [NCPU-1:0]            any_match;
  logic [NCPU-1:0]            mod_match;

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    mesi_e            st_q  [SETS];
    logic [TAG_W-1:0] tag_q [SETS];
    logic             wr_en;
    mesi_e            wr_st;
    logic [TAG_W-1:0] wr_tag;

    always_comb begin
      wr_en  = 1'b0;
      wr_st  = st_q[lk_idx];
      wr_tag = tag_q[lk_idx];
      if (upd_en && req_cpu == CW'(g)) begin
        wr_en  = 1'b1;
        wr_st  = upd_st;
        wr_tag = lk_tag;
      end else if (upd_en && snp_mask[g]) begin
        wr_en = 1'b1;
        wr_st = snp_op ? ST_I : ST_S;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) begin
          st_q[s]  <= ST_I;
          tag_q[s] <= '0;
        end
      end else if (wr_en) begin
        st_q[lk_idx]  <= wr_st;
        tag_q[lk_idx] <= wr_tag;
      end
    end

    assign look_st[g]    = st_q[lk_idx];
    assign tag_rd[g]     = tag_q[lk_idx];
    assign any_match[g]  = (st_q[lk_idx] != ST_I) && (tag_q[lk_idx] == lk_tag);
    assign mod_match[g]  = any_match[g] && (st_q[lk_idx] == ST_M);
    assign others_hit[g] = any_match[g] && (req_cpu != CW'(g));
  end

  assign own_st  = mesi_e'(look_st[req_cpu]);
  assign own_tag = tag_rd[req_cpu];

  // R4: a Modified copy is always the only copy of its line
  a_r4_modified_sole_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (|mod_match) |-> ($countones(any_match) == 1));
endmodule

// File: rtl/scu_coh_ctl.sv
module scu_coh_ctl
  import scu_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int IDX_W = 3,
  parameter int TAG_W = 6,
  localparam int AW = IDX_W + TAG_W,
  localparam int CW = $clog2(NCPU)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_valid,
  input  logic [CW-1:0]        win_cpu,
  input  logic [1:0]           req_op,
  input  logic [AW-1:0]        req_addr,
  input  logic [NCPU-1:0]      others_hit,
  input  logic [NCPU-1:0][1:0] look_st,
  input  mesi_e                own_st,
  input  logic [TAG_W-1:0]     own_tag,
  output mesi_e                gnt_state,
  output logic [NCPU-1:0]      snp_mask,
  output logic                 snp_op,
  output logic                 xfer_valid,
  output logic [CW-1:0]        xfer_src,
  output logic                 nl_fetch,
  output logic [AW-1:0]        nl_addr,
  output logic                 nl_wb,
  output logic [AW-1:0]        nl_wb_addr
);
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [CW-1:0]    src_idx;
  logic [NCPU-1:0]  src_oh;
  logic [NCPU-1:0]  valid_vec;
  mesi_e            src_st;
  logic             inval;

  assign req_idx = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[AW-1:IDX_W];

  // lowest-numbered holder supplies the data
  always_comb begin
    src_idx = '0;
    for (int k = NCPU - 1; k >= 0; k--) begin
      if (others_hit[k]) src_idx = CW'(k);
    end
  end
  assign src_oh = NCPU'(1) << src_idx;
  assign src_st = mesi_e'(look_st[src_idx]);

  for (genvar g = 0; g < NCPU; g++) begin : g_vld
    assign valid_vec[g] = (look_st[g] != ST_I);
  end

  always_comb begin
    gnt_state  = ST_I;
    snp_mask   = '0;
    inval      = 1'b0;
    xfer_valid = 1'b0;
    xfer_src   = '0;
    nl_fetch   = 1'b0;
    nl_addr    = '0;
    nl_wb      = 1'b0;
    nl_wb_addr = '0;
    if (win_valid) begin
      if (req_op[1]) begin
        snp_mask  = others_hit;
        inval     = 1'b1;
        gnt_state = ST_M;
      end else begin
        if (others_hit == '0) begin
          nl_fetch  = 1'b1;
          nl_addr   = req_addr;
          gnt_state = req_op[0] ? ST_M : ST_E;
        end else begin
          xfer_valid = 1'b1;
          xfer_src   = src_idx;
          if (req_op[0]) begin
            snp_mask  = others_hit;
            inval     = 1'b1;
            gnt_state = ST_M;
          end else if (src_st == ST_M) begin
            snp_mask  = src_oh;
            inval     = 1'b1;
            gnt_state = ST_M;
          end else begin
            snp_mask  = src_oh;
            gnt_state = ST_S;
          end
        end
        if (own_st == ST_M && own_tag != req_tag) begin
          nl_wb      = 1'b1;
          nl_wb_addr = {own_tag, req_idx};
        end
      end
    end
  end

  assign snp_op = inval && (snp_mask != '0);

  // R7: snoops reach only CPUs with a live entry, never the requester
  a_r7_snoop_targets_live: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_mask & ~valid_vec) == '0);
  a_r7_no_self_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ((snp_mask & (NCPU'(1) << win_cpu)) == '0));
  // R4: data taken from a Modified owner is installed Modified, owner invalidated
  a_r4_migrate_keeps_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && src_st == ST_M) |-> (gnt_state == ST_M && snp_op));
  // R6: an upgrade moves no data anywhere
  a_r6_upgrade_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && req_op[1]) |-> (!xfer_valid && !nl_fetch && !nl_wb));
endmodule

// File: rtl/snoop_filter_ctl.sv
module snoop_filter_ctl
  import scu_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int IDX_W = 3,
  parameter int TAG_W = 6,
  localparam int AW = IDX_W + TAG_W,
  localparam int CW = $clog2(NCPU)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCPU-1:0]      req_valid,
  input  logic [2*NCPU-1:0]    req_op,
  input  logic [NCPU*AW-1:0]   req_addr,
  output logic [NCPU-1:0]      gnt,
  output logic [1:0]           gnt_state,
  output logic [NCPU-1:0]      snp_mask,
  output logic                 snp_op,
  output logic                 xfer_valid,
  output logic [CW-1:0]        xfer_src,
  output logic                 nl_fetch,
  output logic [AW-1:0]        nl_addr,
  output logic                 nl_wb,
  output logic [AW-1:0]        nl_wb_addr
);
  logic                 rst_meta_q, rst_sync_q;
  logic [NCPU-1:0]      req_live;
  logic                 win_valid;
  logic [CW-1:0]        win_idx;
  logic [1:0]           win_op;
  logic [AW-1:0]        win_addr;
  logic [NCPU-1:0]      others_hit;
  logic [NCPU-1:0][1:0] look_st;
  mesi_e                own_st;
  logic [TAG_W-1:0]     own_tag;
  mesi_e                gst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign req_live = req_valid & {NCPU{rst_sync_q}};
  assign win_op   = req_op[win_idx*2 +: 2];
  assign win_addr = req_addr[win_idx*AW +: AW];

  scu_rr_arb #(.NCPU(NCPU)) u_arb (
    .clk(clk), .rst_n(rst_sync_q), .req(req_live),
    .gnt(gnt), .win_valid(win_valid), .win_idx(win_idx)
  );

  scu_dup_tags #(.NCPU(NCPU), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_dup (
    .clk(clk), .rst_n(rst_sync_q),
    .lk_idx(win_addr[IDX_W-1:0]), .lk_tag(win_addr[AW-1:IDX_W]),
    .req_cpu(win_idx), .others_hit(others_hit), .look_st(look_st),
    .own_st(own_st), .own_tag(own_tag),
    .upd_en(win_valid), .upd_st(gst), .snp_mask(snp_mask), .snp_op(snp_op)
  );

  scu_coh_ctl #(.NCPU(NCPU), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctl (
    .clk(clk), .rst_n(rst_sync_q), .win_valid(win_valid), .win_cpu(win_idx),
    .req_op(win_op), .req_addr(win_addr), .others_hit(others_hit),
    .look_st(look_st), .own_st(own_st), .own_tag(own_tag),
    .gnt_state(gst), .snp_mask(snp_mask), .snp_op(snp_op),
    .xfer_valid(xfer_valid), .xfer_src(xfer_src),
    .nl_fetch(nl_fetch), .nl_addr(nl_addr),
    .nl_wb(nl_wb), .nl_wb_addr(nl_wb_addr)
  );

  assign gnt_state = gst;
endmodule

// File: tb/test_snoop_filter_ctl.sv
module test_snoop_filter_ctl;
  localparam int N = 4, IW = 3, TW = 6, AW = IW + TW, SETS = 1 << IW, CW = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [N-1:0]    req_valid;
  logic [2*N-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N-1:0]    gnt;
  logic [1:0]      gnt_state;
  logic [N-1:0]    snp_mask;
  logic            snp_op, xfer_valid, nl_fetch, nl_wb;
  logic [CW-1:0]   xfer_src;
  logic [AW-1:0]   nl_addr, nl_wb_addr;

  snoop_filter_ctl #(.NCPU(N), .IDX_W(IW), .TAG_W(TW)) i_snoop_filter_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .gnt(gnt), .gnt_state(gnt_state), .snp_mask(snp_mask),
    .snp_op(snp_op), .xfer_valid(xfer_valid), .xfer_src(xfer_src),
    .nl_fetch(nl_fetch), .nl_addr(nl_addr), .nl_wb(nl_wb), .nl_wb_addr(nl_wb_addr)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int m_tag [N][SETS];
  int m_st  [N][SETS];
  int ptr;
  int d_v [N], d_op [N], d_tag [N], d_idx [N];
  int e_w, e_gnt, e_gst, e_snp, e_sop, e_xv, e_xs, e_f, e_fa, e_wb, e_wba;
  string e_req;

  task automatic chk_eq(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic apply_inputs();
    for (int c = 0; c < N; c++) begin
      req_valid[c]          = d_v[c] != 0;
      req_op[c*2 +: 2]      = 2'(d_op[c]);
      req_addr[c*AW +: AW]  = AW'(d_tag[c] * SETS + d_idx[c]);
    end
  endtask

  task automatic model_eval();
    int i, t, hold, src;
    e_w = -1; e_gnt = 0; e_gst = 0; e_snp = 0; e_sop = 0; e_xv = 0; e_xs = 0;
    e_f = 0; e_fa = 0; e_wb = 0; e_wba = 0; e_req = "R11";
    for (int k = 0; k < N; k++)
      if (e_w < 0 && d_v[(ptr + k) % N] != 0) e_w = (ptr + k) % N;
    if (e_w >= 0) begin
      e_gnt = 1 << e_w;
      i = d_idx[e_w]; t = d_tag[e_w];
      hold = 0; src = -1;
      for (int c = 0; c < N; c++)
        if (c != e_w && m_st[c][i] != 0 && m_tag[c][i] == t) begin
          hold |= 1 << c;
          if (src < 0) src = c;
        end
      if (d_op[e_w] >= 2) begin
        e_req = "R6"; e_snp = hold; e_sop = (hold != 0); e_gst = 3;
      end else begin
        if (hold == 0) begin
          e_f = 1; e_fa = t * SETS + i;
          e_gst = (d_op[e_w] == 1) ? 3 : 2;
          e_req = (d_op[e_w] == 1) ? "R5" : "R2";
        end else begin
          e_xv = 1; e_xs = src;
          if (d_op[e_w] == 1) begin
            e_req = "R5"; e_snp = hold; e_sop = 1; e_gst = 3;
          end else if (m_st[src][i] == 3) begin
            e_req = "R4"; e_snp = 1 << src; e_sop = 1; e_gst = 3;
          end else begin
            e_req = "R3"; e_snp = 1 << src; e_sop = 0; e_gst = 1;
          end
        end
        if (m_st[e_w][i] == 3 && m_tag[e_w][i] != t) begin
          e_wb = 1; e_wba = m_tag[e_w][i] * SETS + i;
        end
      end
    end
  endtask

  task automatic compare();
    chk_eq(e_w >= 0 ? "R10" : "R11", int'(gnt), e_gnt);
    chk_eq(e_req, int'(gnt_state), e_gst);
    chk_eq("R7", int'(snp_mask), e_snp);
    chk_eq("R7", int'(snp_op), e_sop);
    chk_eq(e_req, int'(xfer_valid), e_xv);
    chk_eq(e_req, int'(xfer_src), e_xs);
    chk_eq(e_req, int'(nl_fetch), e_f);
    chk_eq(e_req, int'(nl_addr), e_fa);
    chk_eq("R8", int'(nl_wb), e_wb);
    chk_eq("R8", int'(nl_wb_addr), e_wba);
  endtask

  task automatic model_commit();
    int i;
    if (e_w >= 0) begin
      i = d_idx[e_w];
      m_tag[e_w][i] = d_tag[e_w];
      m_st[e_w][i]  = e_gst;
      for (int c = 0; c < N; c++)
        if ((e_snp >> c) & 1) m_st[c][i] = e_sop ? 0 : 1;
      ptr = (e_w + 1) % N;
    end
  endtask

  task automatic step();
    @(negedge clk);
    apply_inputs();
    #2;
    model_eval();
    compare();
    model_commit();
  endtask

  task automatic clear_reqs();
    for (int c = 0; c < N; c++) begin
      d_v[c] = 0; d_op[c] = 0; d_tag[c] = 0; d_idx[c] = 0;
    end
  endtask

  task automatic one(input int c, input int op, input int tag, input int idx);
    clear_reqs();
    d_v[c] = 1; d_op[c] = op; d_tag[c] = tag; d_idx[c] = idx;
    step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_op = '0; req_addr = '0;
    ptr = 0;
    for (int c = 0; c < N; c++)
      for (int s = 0; s < SETS; s++) begin
        m_tag[c][s] = 0; m_st[c][s] = 0;
      end
    clear_reqs();
    repeat (3) @(negedge clk);
    // R1: idle outputs are zero under reset
    chk_eq("R1", int'(gnt), 0);
    chk_eq("R1", int'(snp_mask), 0);
    chk_eq("R1", int'(nl_fetch) + int'(nl_wb) + int'(xfer_valid), 0);
    rst_n = 1'b1;
    repeat (3) step();

    // line A = tag 1 idx 5, B = tag 2 idx 5, C = tag 3 idx 5
    one(0, 0, 1, 5);                      // R2 fetch, Exclusive
    chk_eq("R2", int'(gnt_state), 2);
    one(1, 0, 1, 5);                      // R3 + R9: next cycle sees cpu0
    chk_eq("R9", int'(snp_mask), 1);
    chk_eq("R3", int'(xfer_src), 0);
    one(2, 0, 1, 5);                      // R3 lowest holder supplies
    chk_eq("R3", int'(xfer_src), 0);
    one(1, 2, 1, 5);                      // R6 upgrade invalidates cpu0, cpu2
    chk_eq("R6", int'(snp_mask), 5);
    one(3, 0, 1, 5);                      // R4 migrate from cpu1
    chk_eq("R4", int'(gnt_state), 3);
    chk_eq("R4", int'(snp_mask), 2);
    one(0, 1, 1, 5);                      // R5 write miss takes from cpu3
    chk_eq("R5", int'(xfer_src), 3);
    one(0, 0, 2, 5);                      // R8 dirty victim A
    chk_eq("R8", int'(nl_wb_addr), 1 * SETS + 5);
    one(1, 1, 3, 5);                      // R8 clean/invalid victim, no wb
    chk_eq("R8", int'(nl_wb), 0);

    // R10: four simultaneous requests, pointer at cpu2
    clear_reqs();
    for (int c = 0; c < N; c++) begin
      d_v[c] = 1; d_op[c] = 0; d_tag[c] = 0; d_idx[c] = c;
    end
    step();
    chk_eq("R10", int'(gnt), 4);
    for (int k = 0; k < N - 1; k++) begin
      d_v[e_w] = 0;
      step();
    end
    clear_reqs();
    step();

    // mixed traffic driven from the bench's own state
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < N; c++) begin
        d_v[c]   = int'($urandom % 2);
        d_idx[c] = int'($urandom % SETS);
        d_tag[c] = int'($urandom % 4);
        if (m_st[c][d_idx[c]] != 0 && m_tag[c][d_idx[c]] == d_tag[c]) begin
          if (m_st[c][d_idx[c]] == 3) d_v[c] = 0;
          d_op[c] = 2 + int'($urandom % 2);
        end else begin
          d_op[c] = int'($urandom % 2);
        end
      end
      step();
    end
    clear_reqs();
    step();

    done = 1;
    summary();
    $finish;
  end
endmodule